// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a synthesizable model of a synchronous static RAM with a processor-style burst front end. Every input is captured on the rising clock edge: address, write data and control. The word width is split into byte lanes, and each lane has its own active-low write enable. Read data passes through an array read register and then an output register before it reaches the shared bidirectional data bus. The bus drivers are gated asynchronously by an active-low output enable.

A burst is opened by one of two active-low address strobes. The processor strobe counts only while the chip select is low. The controller strobe is never gated. The address sampled with the strobe becomes the first beat. A separate active-low advance input steps a 2-bit beat counter. The low two address bits of each beat are the start bits XOR the counter, so a burst covers four words and wraps inside the aligned group of four.

A cycle opened by the processor strobe is always a read. Writes happen on cycles opened by the controller strobe or on advance cycles, and only in the lanes whose enable is low. The depth is set by the address width parameter. The default is 1K words of 18 bits, and 64K words are obtained with an address width of 16.

Top module: `pipe_burst_sram`

## Requirements
- R1: A read started at rising edge E, with `oe_n` low, shows the addressed word on `dq` after edge E+2 and not before.
- R2: The beat counter steps once for each cycle in which `adv_n` is sampled low and no strobe starts a burst. The beat address is {start[ADDR_W-1:2], start[1:0] XOR count}, so a burst from low bits 2 visits 2,3,0,1 and the upper bits never change.
- R3: The beat address holds when no burst starts and `adv_n` is sampled high. Repeated cycles then return the same word.
- R4: A low `strb_proc_n` sampled while `sel_n` is high is ignored, and the burst address is unchanged.
- R5: A low `strb_ctrl_n` starts a burst whatever the level of `sel_n`.
- R6: A cycle whose burst is started by a qualified processor strobe never writes, even with the lane enables low.
- R7: On a controller-strobe cycle or an advance cycle, `lane_we_n[0]` low writes `dq[8:0]` and `lane_we_n[1]` low writes `dq[17:9]`. A lane whose enable is high keeps its old contents.
- R8: An advance cycle with both lane enables high writes nothing.
- R9: With `oe_n` high, `dq` is released at once, in the middle of a cycle. With `oe_n` low, the registered output is driven again without waiting for a clock edge.
- R10: While `rst_n` is low, the output register reads zero. With `oe_n` low, `dq` then reads 0.
- R11: If both strobes are sampled low and the processor strobe is qualified, the cycle is a read that starts at the sampled address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset of the control and pipeline registers |
| addr | input | ADDR_W | Word address, loaded when a burst starts |
| dq | inout | LANE_W*LANES | Shared data bus: write data in, read data out |
| lane_we_n | input | LANES | Active-low write enable, one bit per byte lane |
| oe_n | input | 1 | Active-low asynchronous output enable |
| strb_proc_n | input | 1 | Active-low processor address strobe, qualified by sel_n |
| strb_ctrl_n | input | 1 | Active-low controller address strobe, not qualified |
| adv_n | input | 1 | Active-low burst advance |
| sel_n | input | 1 | Active-low chip select, applied to the processor strobe only |

## Verification
The embedded properties check on every cycle that the burst base never moves while the counter steps or holds. They also check that the counter increments by exactly one on an advance, that an unqualified processor strobe leaves the burst address alone, and that the output register comes out of reset cleared. The bench scenarios cover what needs the array contents. These are the interleaved beat order, the two-cycle read latency, the lane masking of partial writes, and the fact that processor-strobe cycles and advance cycles with both enables high do not write. The scenarios also cover the priority when both strobes are low and the asynchronous release and recapture of the bus in the middle of a cycle.

// File: rtl/pbs_pkg.sv
`timescale 1ns/1ps
package pbs_pkg;
   localparam int unsigned BEAT_W = 2;
   localparam int unsigned BEATS  = 1 << BEAT_W;

   typedef logic [BEAT_W-1:0] beat_t;

   // Interleaved beat order: low address bits of a beat.
   function automatic beat_t beat_low(input beat_t first, input beat_t idx);
      return first ^ idx;
   endfunction
endpackage

// File: rtl/pbs_in_reg.sv
`timescale 1ns/1ps
module pbs_in_reg #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 18,
   parameter int LANES  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic [LANES-1:0]  we_n_i,
   input  logic              strb_p_n_i,
   input  logic              strb_c_n_i,
   input  logic              adv_n_i,
   input  logic              sel_n_i,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] data_q,
   output logic [LANES-1:0]  we_n_q,
   output logic              strb_p_n_q,
   output logic              strb_c_n_q,
   output logic              adv_n_q,
   output logic              sel_n_q
);
   // Address and data carry no reset.
   always_ff @(posedge clk) begin
      addr_q <= addr_i;
      data_q <= data_i;
   end

   // Control inputs reset to their inactive level.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_n_q     <= '1;
         strb_p_n_q <= 1'b1;
         strb_c_n_q <= 1'b1;
         adv_n_q    <= 1'b1;
         sel_n_q    <= 1'b1;
      end else begin
         we_n_q     <= we_n_i;
         strb_p_n_q <= strb_p_n_i;
         strb_c_n_q <= strb_c_n_i;
         adv_n_q    <= adv_n_i;
         sel_n_q    <= sel_n_i;
      end
   end
endmodule

// File: rtl/pbs_burst_ctr.sv
`timescale 1ns/1ps
module pbs_burst_ctr
   import pbs_pkg::*;
#(
   parameter int ADDR_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              step_i,
   input  logic [ADDR_W-1:0] load_i,
   output logic [ADDR_W-1:0] eff_o,
   output logic [ADDR_W-1:0] base_o
);
   localparam int HI_W = ADDR_W - BEAT_W;

   logic [ADDR_W-1:0] base_q;
   beat_t             cnt_q;
   beat_t             idx;

   always_comb begin
      idx = step_i ? beat_t'(cnt_q + beat_t'(1)) : cnt_q;
      if (start_i)
         eff_o = load_i;
      else
         eff_o = {base_q[ADDR_W-1 -: HI_W], beat_low(base_q[BEAT_W-1:0], idx)};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         cnt_q  <= '0;
      end else if (start_i) begin
         base_q <= load_i;
         cnt_q  <= '0;
      end else if (step_i) begin
         cnt_q  <= cnt_q + beat_t'(1);
      end
   end

   assign base_o = base_q;

   // R2: an advance moves the counter by exactly one.
   a_r2_step_one: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_i && step_i) |=> (cnt_q == beat_t'($past(cnt_q) + beat_t'(1))));

   // R2: the burst base stays put while beats step, so the burst wraps in its group.
   a_r2_base_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_i && step_i) |=> (base_q == $past(base_q)));

   // R3: with no strobe and no advance the beat address holds.
   a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_i && !step_i) |=> ($stable(cnt_q) && $stable(base_q)));
endmodule

// File: rtl/pbs_array.sv
`timescale 1ns/1ps
module pbs_array #(
   parameter int ADDR_W = 10,
   parameter int LANE_W = 9,
   parameter int LANES  = 2
) (
   input  logic                    clk,
   input  logic [ADDR_W-1:0]       addr_i,
   input  logic [LANES-1:0]        wr_lane_i,
   input  logic [LANE_W*LANES-1:0] wdata_i,
   output logic [LANE_W*LANES-1:0] rdata_o
);
   localparam int DEPTH = 1 << ADDR_W;

   // One storage array and one read register per byte lane.
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] mem [DEPTH];
      logic [LANE_W-1:0] rd_q;

      always_ff @(posedge clk) begin
         if (wr_lane_i[g])
            mem[addr_i] <= wdata_i[g*LANE_W +: LANE_W];
         rd_q <= mem[addr_i];
      end

      assign rdata_o[g*LANE_W +: LANE_W] = rd_q;
   end
endmodule

// File: rtl/pbs_out_stage.sv
`timescale 1ns/1ps
module pbs_out_stage #(
   parameter int DATA_W = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] rd_i,
   output logic [DATA_W-1:0] dout_o
);
   logic [DATA_W-1:0] dout_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dout_q <= '0;
      else        dout_q <= rd_i;
   end

   assign dout_o = dout_q;

   // R10: the output register is cleared at the first edge after reset.
   a_r10_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (dout_q == '0));
endmodule

// File: rtl/pipe_burst_sram.sv
`timescale 1ns/1ps
module pipe_burst_sram #(
   parameter int ADDR_W = 10,
   parameter int LANE_W = 9,
   parameter int LANES  = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ADDR_W-1:0]       addr,
   inout  wire  [LANE_W*LANES-1:0] dq,
   input  logic [LANES-1:0]        lane_we_n,
   input  logic                    oe_n,
   input  logic                    strb_proc_n,
   input  logic                    strb_ctrl_n,
   input  logic                    adv_n,
   input  logic                    sel_n
);
   localparam int DATA_W = LANE_W * LANES;

   if (ADDR_W < pbs_pkg::BEAT_W + 1 || ADDR_W > 16) begin : g_bad_addr_w
      $error("pipe_burst_sram: ADDR_W out of range");
   end
   if (LANE_W < 1 || LANES < 1) begin : g_bad_lanes
      $error("pipe_burst_sram: lane shape invalid");
   end

   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   logic [LANES-1:0]  we_n_q;
   logic              strb_p_q, strb_c_q, adv_q, sel_q;

   pbs_in_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_in (
      .clk        (clk),
      .rst_n      (rst_n),
      .addr_i     (addr),
      .data_i     (dq),
      .we_n_i     (lane_we_n),
      .strb_p_n_i (strb_proc_n),
      .strb_c_n_i (strb_ctrl_n),
      .adv_n_i    (adv_n),
      .sel_n_i    (sel_n),
      .addr_q     (addr_q),
      .data_q     (data_q),
      .we_n_q     (we_n_q),
      .strb_p_n_q (strb_p_q),
      .strb_c_n_q (strb_c_q),
      .adv_n_q    (adv_q),
      .sel_n_q    (sel_q)
   );

   logic             p_go, c_go, go, stp, wr_cyc;
   logic [LANES-1:0] wr_lane;

   always_comb begin
      p_go    = !strb_p_q && !sel_q;
      c_go    = !strb_c_q;
      go      = p_go || c_go;
      stp     = !adv_q && !go;
      wr_cyc  = !p_go && (c_go || stp);
      wr_lane = wr_cyc ? ~we_n_q : '0;
   end

   logic [ADDR_W-1:0] eff, base;

   pbs_burst_ctr #(.ADDR_W(ADDR_W)) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (go),
      .step_i  (stp),
      .load_i  (addr_q),
      .eff_o   (eff),
      .base_o  (base)
   );

   logic [DATA_W-1:0] rdata, dout;

   pbs_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_arr (
      .clk       (clk),
      .addr_i    (eff),
      .wr_lane_i (wr_lane),
      .wdata_i   (data_q),
      .rdata_o   (rdata)
   );

   pbs_out_stage #(.DATA_W(DATA_W)) u_out (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_i   (rdata),
      .dout_o (dout)
   );

   assign dq = oe_n ? {DATA_W{1'bz}} : dout;

   // R4: an unqualified processor strobe with no other request leaves the burst where it is.
   a_r4_sel_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (!strb_p_q && sel_q && strb_c_q && adv_q) |=> (base == $past(base)));

   // R5: a controller strobe loads the sampled address whatever the chip select.
   a_r5_ctrl_load: assert property (@(posedge clk) disable iff (!rst_n)
      !strb_c_q |=> (base == $past(addr_q)));
endmodule

// File: tb/sim_pipe_burst_sram.sv
`timescale 1ns/1ps
module sim_pipe_burst_sram;
   localparam int AW = 10;
   localparam int DW = 18;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [1:0]    lane_we_n = 2'b11;
   logic          oe_n = 1'b0;
   logic          strb_proc_n = 1'b1, strb_ctrl_n = 1'b1, adv_n = 1'b1, sel_n = 1'b1;
   logic          drv_en = 1'b0;
   logic [DW-1:0] drv_val = '0;
   wire  [DW-1:0] dq;

   assign dq = drv_en ? drv_val : {DW{1'bz}};

   always #2 clk = ~clk;   // 250 MHz

   pipe_burst_sram #(.ADDR_W(AW), .LANE_W(9), .LANES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .addr(addr), .dq(dq), .lane_we_n(lane_we_n),
      .oe_n(oe_n), .strb_proc_n(strb_proc_n), .strb_ctrl_n(strb_ctrl_n),
      .adv_n(adv_n), .sel_n(sel_n)
   );

   int n_chk = 0, n_fail = 0, edge_cnt = 0;
   bit done = 0;

   always @(posedge clk) edge_cnt <= edge_cnt + 1;

   // Reference model built from the requirements.
   logic [DW-1:0] ref_mem [1 << AW];
   bit            kn_a [1 << AW];
   bit            kn_b [1 << AW];
   logic [AW-1:0] m_base = '0;
   logic [1:0]    m_cnt = '0;

   // Scoreboard queues.
   int            due_q[$];
   logic [DW-1:0] dat_q[$];
   string         tag_q[$];

   task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: dq=%h expected %h", tag, act, exp);
      end
   endtask

   // Driver: presents one cycle and pushes the expected read result.
   task automatic cyc(input string tag, input logic p_n, input logic c_n, input logic a_n,
                      input logic s_n, input logic [1:0] we, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, input logic bus);
      logic ps, cst, st, stp, wr;
      logic [1:0] idx;
      logic [AW-1:0] eff;
      @(negedge clk); #1;
      strb_proc_n = p_n; strb_ctrl_n = c_n; adv_n = a_n; sel_n = s_n;
      lane_we_n = we; addr = a; drv_val = d; drv_en = bus; oe_n = bus;
      ps  = !p_n && !s_n;
      cst = !c_n;
      st  = ps || cst;
      stp = !a_n && !st;
      idx = stp ? m_cnt + 2'd1 : m_cnt;
      eff = st ? a : {m_base[AW-1:2], m_base[1:0] ^ idx};
      wr  = !ps && (cst || stp) && (we != 2'b11);
      if (!wr) begin
         if (kn_a[eff] && kn_b[eff]) begin
            due_q.push_back(edge_cnt + 3);
            dat_q.push_back(ref_mem[eff]);
            tag_q.push_back(tag);
         end
      end else begin
         if (!we[0]) begin ref_mem[eff][8:0]  = d[8:0];  kn_a[eff] = 1; end
         if (!we[1]) begin ref_mem[eff][17:9] = d[17:9]; kn_b[eff] = 1; end
      end
      if (st) begin m_base = a; m_cnt = 2'd0; end
      else if (stp) m_cnt = m_cnt + 2'd1;
   endtask

   task automatic hold(input string tag);
      cyc(tag, 1, 1, 1, 0, 2'b11, '0, '0, 0);
   endtask

   function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
      return {8'hC3, a};
   endfunction

   // Monitor: compares the bus against the queue head when it falls due.
   initial begin
      forever begin
         @(negedge clk);
         while (due_q.size() > 0 && due_q[0] <= edge_cnt) begin
            if (due_q[0] == edge_cnt && !oe_n && !drv_en)
               chk(tag_q[0], dq, dat_q[0]);
            void'(due_q.pop_front());
            void'(dat_q.pop_front());
            void'(tag_q.pop_front());
         end
      end
   end

   initial begin
      #800000;
      if (!done) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog: run did not finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < (1 << AW); i++) begin kn_a[i] = 0; kn_b[i] = 0; ref_mem[i] = '0; end
      // R10: reset state of the output path
      repeat (4) @(posedge clk);
      @(negedge clk);
      chk("R10 reset output", dq, '0);
      #1 rst_n = 1'b1;

      // R7/R2: burst writes through controller strobe and advances
      cyc("R7 fill", 1, 0, 1, 1, 2'b00, 10'h040, 18'h15555, 1);
      cyc("R7 fill", 1, 1, 0, 1, 2'b00, '0, pat(10'h041), 1);
      cyc("R7 fill", 1, 1, 0, 1, 2'b00, '0, pat(10'h042), 1);
      cyc("R7 fill", 1, 1, 0, 1, 2'b00, '0, pat(10'h043), 1);
      cyc("R7 fill", 1, 0, 1, 1, 2'b00, 10'h045, pat(10'h045), 1);
      for (int k = 0; k < 3; k++) cyc("R7 fill", 1, 1, 0, 1, 2'b00, '0, 18'h00A00 + 18'(k), 1);
      cyc("R7 fill", 1, 0, 1, 1, 2'b00, 10'h01A, pat(10'h01A), 1);
      for (int k = 0; k < 3; k++) cyc("R7 fill", 1, 1, 0, 1, 2'b00, '0, 18'h00B00 + 18'(k), 1);

      // R1 / R2: processor read burst from low bits 2 visits 2,3,0,1
      cyc("R1 first beat", 0, 1, 1, 0, 2'b11, 10'h042, '0, 0);
      cyc("R2 beat 43", 1, 1, 0, 0, 2'b11, '0, '0, 0);
      cyc("R2 beat 40 wrap", 1, 1, 0, 0, 2'b11, '0, '0, 0);
      cyc("R2 beat 41", 1, 1, 0, 0, 2'b11, '0, '0, 0);
      hold("R3 hold");
      hold("R3 hold");

      // R9: asynchronous output enable while holding word 0x40
      cyc("R1 read 40", 0, 1, 1, 0, 2'b11, 10'h040, '0, 0);
      hold("R3 hold 40");
      hold("R3 hold 40");
      hold("R3 hold 40");
      @(negedge clk); #1;
      oe_n = 1'b1; drv_val = 18'h2AAAA; drv_en = 1'b1;
      #0.5 chk("R9 bus released", dq, 18'h2AAAA);
      oe_n = 1'b0; drv_en = 1'b0;
      #0.5 chk("R9 bus redriven", dq, 18'h15555);

      // R4: unqualified processor strobe is ignored
      cyc("R4 ignored strobe", 0, 1, 1, 1, 2'b11, 10'h01A, '0, 0);
      hold("R4 still 40");

      // R5: controller strobe with chip select high
      cyc("R5 ctrl read 47", 1, 0, 1, 1, 2'b11, 10'h047, '0, 0);
      cyc("R2 beat 46", 1, 1, 0, 1, 2'b11, '0, '0, 0);
      cyc("R5 ctrl+proc ungated", 0, 0, 1, 1, 2'b11, 10'h041, '0, 0);
      hold("R5 hold 41");

      // R6: processor strobe with enables low does not write
      cyc("R6 no write", 0, 1, 1, 0, 2'b00, 10'h044, 18'h3FFFF, 1);
      hold("R6 gap");
      cyc("R6 read 44", 0, 1, 1, 0, 2'b11, 10'h044, '0, 0);
      hold("R6 hold 44");

      // R7: lane masking
      cyc("R7 lane a", 1, 0, 1, 0, 2'b10, 10'h045, 18'h3FFFF, 1);
      cyc("R7 lane b", 1, 1, 0, 0, 2'b01, '0, 18'h00000, 1);
      hold("R7 gap");
      cyc("R7 read 45", 0, 1, 1, 0, 2'b11, 10'h045, '0, 0);
      cyc("R7 read 44", 1, 1, 0, 0, 2'b11, '0, '0, 0);
      hold("R7 hold 44");

      // R8: advance with both enables high writes nothing
      cyc("R8 no write", 1, 1, 0, 0, 2'b11, '0, 18'h00000, 1);
      hold("R8 gap");
      cyc("R8 read 47", 0, 1, 1, 0, 2'b11, 10'h047, '0, 0);
      hold("R8 hold 47");

      // R11: both strobes low, processor qualified: read only
      cyc("R11 both strobes", 0, 0, 1, 0, 2'b00, 10'h01B, 18'h00000, 1);
      hold("R11 gap");
      cyc("R11 read 1B", 0, 1, 1, 0, 2'b11, 10'h01B, '0, 0);
      cyc("R2 beat 1A", 1, 1, 0, 0, 2'b11, '0, '0, 0);
      cyc("R2 beat 19", 1, 1, 0, 0, 2'b11, '0, '0, 0);
      cyc("R2 beat 18", 1, 1, 0, 0, 2'b11, '0, '0, 0);
      hold("R3 final hold");
      repeat (5) @(negedge clk);

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule